// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a 32-bit core and a word-wide data memory. For each request it adds a sign-extended 16-bit displacement to a 32-bit base to form a byte address. It presents the memory with the containing word address. For stores it places the source bytes on the correct lanes and raises one write enable per written byte. For loads it picks the addressed byte or halfword out of the returned word, extends it to 32 bits and registers the result.

Lane mapping is big-endian: the byte whose address equals the word address travels on the most significant lane. Halfword accesses must sit on even addresses and word accesses on multiples of four. The unit does not split a misaligned request. It raises a flag and suppresses every write enable instead.

The memory is expected to return read data in the same cycle as the address, so `memRdata` is combinational from `memAddr`. The extended load value appears on `ldData` one clock later, and `ldValid` strobes high for that one cycle.

Top module: `be_lane_lsu`

## Requirements
- R1: `memAddr` equals `reqBase` plus the sign-extended `reqOffset`, taken modulo 2^32, with bits 1:0 forced to zero. It is valid in the same cycle as the request.
- R2: `reqOp` is encoded as follows. Bit 3 is 1 for a store and 0 for a load. Bit 2 is 1 for an unsigned load. Bits 1:0 give the size: 00 is byte, 01 is halfword, and 10 or 11 is word. Bit 2 has no effect on stores. A word store at an aligned address drives `memBe` = 4'b1111 and `memWdata` = `reqWdata`.
- R3: A byte store at lane offset k (address bits 1:0) raises only `memBe` bit 3-k. Bit 3 is the most significant lane, `memWdata[31:24]`. The low byte of `reqWdata` appears on that lane.
- R4: A halfword store at offset 0 drives `memBe` = 4'b1100. At offset 2 it drives 4'b0011. In both cases the low halfword of `reqWdata` sits on the enabled lanes, with its upper byte on the more significant lane.
- R5: The request is misaligned when it is a word access with address bits 1:0 other than 00, or a halfword access with address bit 0 set. A valid misaligned request raises `misalign` in the same cycle and forces `memBe` to 0. It produces no `ldValid`.
- R6: A signed byte load at offset k returns `memRdata[31-8k:24-8k]`, sign-extended to 32 bits.
- R7: Unsigned byte and halfword loads (bit 2 set) zero-extend the selected bits to 32 bits.
- R8: A halfword load at offset 0 selects `memRdata[31:16]`, and at offset 2 it selects `memRdata[15:0]`. A signed halfword load sign-extends the selected value.
- R9: A word load returns `memRdata` unchanged, whatever the value of bit 2.
- R10: For an accepted aligned load, `ldData` takes the result at the next rising edge and `ldValid` is high for exactly that one cycle. `ldData` then holds until the next accepted load.
- R11: During reset `ldValid` and `ldData` are 0. While `reqValid` is low, `memBe` is 0 and `misalign` is 0, whatever the other request inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 4 | {store, unsigned, size[1:0]} |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 16 | Signed displacement |
| reqWdata | input | 32 | Store source register |
| memAddr | output | 32 | Word address to memory |
| memBe | output | 4 | Per-lane write enables, bit 3 = lane at word address |
| memWdata | output | 32 | Lane-steered store data |
| memRdata | input | 32 | Word returned by memory for memAddr |
| ldData | output | 32 | Registered, extended load result |
| ldValid | output | 1 | One-cycle strobe marking a new ldData |
| misalign | output | 1 | Current request is misaligned |

## Verification
Several properties are checked on every clock by assertions:
- a misaligned request, a load or an idle cycle never writes;
- a byte store enables exactly one lane and a halfword store exactly two;
- `ldValid` only follows an accepted load;
- `ldData` stays stable in cycles with no accepted load.

The bench's scenarios are needed to show which lane is chosen and the data values on it. They also cover sign versus zero extension, address wrap-around with negative displacements, and back-to-back load timing.

// File: rtl/lane_pkg.sv
package lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    logic  storeEn;
    logic  loadEn;
    size_e size;
    logic  zeroExt;
    logic  misalign;
  } lane_strobe_t;

endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic                 reqValid,
  input  logic [3:0]           reqOp,
  input  logic [LANE_BITS-1:0] eaLow,
  output lane_strobe_t         strobe
);

  size_e accSize;
  logic  badAlign;

  always_comb begin
    if (reqOp[1])      accSize = SZ_WORD;
    else if (reqOp[0]) accSize = SZ_HALF;
    else               accSize = SZ_BYTE;
  end

  always_comb begin
    case (accSize)
      SZ_WORD: badAlign = (eaLow != '0);
      SZ_HALF: badAlign = eaLow[0];
      default: badAlign = 1'b0;
    endcase
  end

  always_comb begin
    strobe.size     = accSize;
    strobe.zeroExt  = reqOp[2];
    strobe.misalign = reqValid & badAlign;
    strobe.storeEn  = reqValid & reqOp[3] & ~badAlign;
    strobe.loadEn   = reqValid & ~reqOp[3] & ~badAlign;
  end

endmodule

// File: rtl/lane_dp.sv
module lane_dp
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               reqBase,
  input  logic [OFF_W-1:0]                reqOffset,
  input  logic [DATA_W-1:0]               reqWdata,
  input  lane_strobe_t                    strobe,
  output logic [$clog2(DATA_W/8)-1:0]     eaLow,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [DATA_W/8-1:0]             memBe,
  output logic [DATA_W-1:0]               memWdata,
  input  logic [DATA_W-1:0]               memRdata,
  output logic [DATA_W-1:0]               ldData,
  output logic                            ldValid
);

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic [ADDR_W-1:0] effAddr;

  assign effAddr = reqBase + {{(ADDR_W-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};
  assign eaLow   = effAddr[LANE_BITS-1:0];
  assign memAddr = {effAddr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};

  // Store steering: lane g is the g-th byte from the word address (MSB first)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * g;
    logic       byteHit;
    logic       halfHit;
    logic [7:0] laneData;

    assign byteHit = (strobe.size == SZ_BYTE) && (eaLow == LANE_BITS'(g));
    assign halfHit = (strobe.size == SZ_HALF) && (eaLow == LANE_BITS'(g & ~1));
    assign memBe[LANES-1-g] = strobe.storeEn &
                              (byteHit | halfHit | (strobe.size == SZ_WORD));

    always_comb begin
      case (strobe.size)
        SZ_BYTE: laneData = reqWdata[7:0];
        SZ_HALF: laneData = (g % 2 == 0) ? reqWdata[15:8] : reqWdata[7:0];
        default: laneData = reqWdata[HI -: 8];
      endcase
    end

    assign memWdata[HI -: 8] = laneData;
  end

  // Load extraction: shift the addressed bytes to the top, then extend
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] ldNext;

  assign shifted = memRdata << {eaLow, 3'b000};

  always_comb begin
    case (strobe.size)
      SZ_BYTE: ldNext = strobe.zeroExt
                        ? {{(DATA_W-8){1'b0}}, shifted[DATA_W-1 -: 8]}
                        : {{(DATA_W-8){shifted[DATA_W-1]}}, shifted[DATA_W-1 -: 8]};
      SZ_HALF: ldNext = strobe.zeroExt
                        ? {{(DATA_W-16){1'b0}}, shifted[DATA_W-1 -: 16]}
                        : {{(DATA_W-16){shifted[DATA_W-1]}}, shifted[DATA_W-1 -: 16]};
      default: ldNext = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldData  <= '0;
      ldValid <= 1'b0;
    end else begin
      ldValid <= strobe.loadEn;
      if (strobe.loadEn) ldData <= ldNext;
    end
  end

  // R5
  mis_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.misalign |-> (memBe == '0));

  // R2
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |-> (memBe == '0));

  // R3
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeEn && strobe.size == SZ_BYTE) |-> ($countones(memBe) == 1));

  // R4
  half_two_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeEn && strobe.size == SZ_HALF) |-> ($countones(memBe) == 2));

  // R10
  ld_valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> $past(strobe.loadEn));

  // R10
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(ldData));

endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [3:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqBase,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]   ldData,
  output logic                ldValid,
  output logic                misalign
);

  localparam int LANE_BITS = $clog2(DATA_W / 8);

  lane_strobe_t         strobe;
  logic [LANE_BITS-1:0] eaLow;

  lane_ctrl #(.LANE_BITS(LANE_BITS)) u_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .eaLow    (eaLow),
    .strobe   (strobe)
  );

  lane_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqBase   (reqBase),
    .reqOffset (reqOffset),
    .reqWdata  (reqWdata),
    .strobe    (strobe),
    .eaLow     (eaLow),
    .memAddr   (memAddr),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .ldData    (ldData),
    .ldValid   (ldValid)
  );

  assign misalign = strobe.misalign;

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (memBe == '0 && !misalign));

  // R10
  no_ld_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !ldValid);

endmodule

// File: tb/sim_be_lane_lsu.sv
`timescale 1ns/100ps
module sim_be_lane_lsu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqOp = '0;
  logic [31:0] reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr;
  logic [3:0]  memBe;
  logic [31:0] memWdata;
  logic [31:0] ldData;
  logic        ldValid;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] lastLd = '0;

  always #2.5 clk = ~clk;

  be_lane_lsu u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqWdata(reqWdata),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .ldData(ldData), .ldValid(ldValid),
    .misalign(misalign)
  );

  // {op, base, off, wdata, rdata, expAddr, expBe, expWd, expMis, expLd}
  localparam int NV = 34;
  localparam logic [216:0] TBL [NV] = '{
    {4'h2, 32'h00001000, 16'h0004, 32'h0, 32'h8C7DE561, 32'h00001004, 4'h0, 32'h0, 1'b0, 32'h8C7DE561},
    {4'h2, 32'h00001000, 16'hFFFC, 32'h0, 32'h8C7DE561, 32'h00000FFC, 4'h0, 32'h0, 1'b0, 32'h8C7DE561},
    {4'h3, 32'h00001000, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00001000, 4'h0, 32'h0, 1'b0, 32'h8C7DE561},
    {4'h6, 32'h00001000, 16'h0008, 32'h0, 32'h8C7DE561, 32'h00001008, 4'h0, 32'h0, 1'b0, 32'h8C7DE561},
    {4'h0, 32'h00002000, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00002000, 4'h0, 32'h0, 1'b0, 32'hFFFFFF8C},
    {4'h0, 32'h00002000, 16'h0001, 32'h0, 32'h8C7DE561, 32'h00002000, 4'h0, 32'h0, 1'b0, 32'h0000007D},
    {4'h0, 32'h00002003, 16'hFFFF, 32'h0, 32'h8C7DE561, 32'h00002000, 4'h0, 32'h0, 1'b0, 32'hFFFFFFE5},
    {4'h0, 32'h00002000, 16'h0003, 32'h0, 32'h8C7DE561, 32'h00002000, 4'h0, 32'h0, 1'b0, 32'h00000061},
    {4'h4, 32'h00002000, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00002000, 4'h0, 32'h0, 1'b0, 32'h0000008C},
    {4'h4, 32'h00002000, 16'h0002, 32'h0, 32'h8C7DE561, 32'h00002000, 4'h0, 32'h0, 1'b0, 32'h000000E5},
    {4'h1, 32'h00003000, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b0, 32'hFFFF8C7D},
    {4'h1, 32'h00003000, 16'h0002, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b0, 32'hFFFFE561},
    {4'h5, 32'h00003000, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b0, 32'h00008C7D},
    {4'h5, 32'h00003000, 16'h0002, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b0, 32'h0000E561},
    {4'h1, 32'h00003000, 16'h0001, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b1, 32'h0},
    {4'h2, 32'h00003000, 16'h0002, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b1, 32'h0},
    {4'h2, 32'h00003001, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b1, 32'h0},
    {4'h5, 32'h00003003, 16'h0000, 32'h0, 32'h8C7DE561, 32'h00003000, 4'h0, 32'h0, 1'b1, 32'h0},
    {4'hA, 32'h00004000, 16'h0010, 32'hA1B2C3D4, 32'h0, 32'h00004010, 4'hF, 32'hA1B2C3D4, 1'b0, 32'h0},
    {4'h8, 32'h00004000, 16'h0000, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h8, 32'hD4D4D4D4, 1'b0, 32'h0},
    {4'h8, 32'h00004000, 16'h0001, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h4, 32'hD4D4D4D4, 1'b0, 32'h0},
    {4'h8, 32'h00004000, 16'h0002, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h2, 32'hD4D4D4D4, 1'b0, 32'h0},
    {4'h8, 32'h00004003, 16'h0000, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h1, 32'hD4D4D4D4, 1'b0, 32'h0},
    {4'h9, 32'h00004000, 16'h0000, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'hC, 32'hC3D4C3D4, 1'b0, 32'h0},
    {4'h9, 32'h00004000, 16'h0002, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h3, 32'hC3D4C3D4, 1'b0, 32'h0},
    {4'h9, 32'h00004000, 16'h0003, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h0, 32'h0, 1'b1, 32'h0},
    {4'hA, 32'h00004000, 16'h0001, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h0, 32'h0, 1'b1, 32'h0},
    {4'hE, 32'h00004000, 16'h0004, 32'hA1B2C3D4, 32'h0, 32'h00004004, 4'hF, 32'hA1B2C3D4, 1'b0, 32'h0},
    {4'h2, 32'hFFFFFFF0, 16'h0010, 32'h0, 32'h8C7DE561, 32'h00000000, 4'h0, 32'h0, 1'b0, 32'h8C7DE561},
    {4'h2, 32'h00000004, 16'h8000, 32'h0, 32'h8C7DE561, 32'hFFFF8004, 4'h0, 32'h0, 1'b0, 32'h8C7DE561},
    {4'hC, 32'h00004000, 16'h0002, 32'hA1B2C3D4, 32'h0, 32'h00004000, 4'h2, 32'hD4D4D4D4, 1'b0, 32'h0},
    {4'h0, 32'h00005000, 16'h0003, 32'h0, 32'h7F00FF80, 32'h00005000, 4'h0, 32'h0, 1'b0, 32'hFFFFFF80},
    {4'h1, 32'h00005000, 16'h0000, 32'h0, 32'h7F00FF80, 32'h00005000, 4'h0, 32'h0, 1'b0, 32'h00007F00},
    {4'h4, 32'h00005000, 16'h0002, 32'h0, 32'h7F00FF80, 32'h00005000, 4'h0, 32'h0, 1'b0, 32'h000000FF}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [3:0] op, input logic mis);
    if (mis)            return "R5";
    if (op[3]) begin
      if (op[1])        return "R2";
      else if (op[0])   return "R4";
      else              return "R3";
    end
    if (op[1])          return "R9";
    if (op[2])          return "R7";
    if (op[0])          return "R8";
    return "R6";
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    // R11: reset state and idle quietness
    repeat (2) @(negedge clk);
    chk("R11", "ldValid in reset", {31'b0, ldValid}, 32'h0);
    chk("R11", "ldData in reset", ldData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    reqOp = 4'hA; reqBase = 32'h00004001; reqWdata = 32'hFFFFFFFF;
    #1;
    chk("R11", "memBe idle", {28'b0, memBe}, 32'h0);
    chk("R11", "misalign idle", {31'b0, misalign}, 32'h0);
    @(negedge clk);
    chk("R11", "ldValid idle", {31'b0, ldValid}, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [31:0] eAddr, eWd, eLd;
      logic [3:0]  eBe;
      logic        eMis;
      string       tg;
      op    = TBL[i][216:213];
      eAddr = TBL[i][100:69];
      eBe   = TBL[i][68:65];
      eWd   = TBL[i][64:33];
      eMis  = TBL[i][32];
      eLd   = TBL[i][31:0];
      tg    = tagOf(op, eMis);
      @(negedge clk);
      reqValid  = 1'b1;
      reqOp     = op;
      reqBase   = TBL[i][212:181];
      reqOffset = TBL[i][180:165];
      reqWdata  = TBL[i][164:133];
      memRdata  = TBL[i][132:101];
      #1;
      chk("R1", $sformatf("memAddr v%0d", i), memAddr, eAddr);
      chk(tg, $sformatf("misalign v%0d", i), {31'b0, misalign}, {31'b0, eMis});
      chk(tg, $sformatf("memBe v%0d", i), {28'b0, memBe}, {28'b0, eBe});
      if (eBe != 4'h0)
        chk(tg, $sformatf("memWdata v%0d", i), memWdata, eWd);
      @(negedge clk);
      reqValid = 1'b0;
      if (!op[3] && !eMis) begin
        chk("R10", $sformatf("ldValid v%0d", i), {31'b0, ldValid}, 32'h1);
        chk(tg, $sformatf("ldData v%0d", i), ldData, eLd);
        lastLd = eLd;
      end else begin
        chk("R10", $sformatf("ldValid v%0d", i), {31'b0, ldValid}, 32'h0);
        chk("R10", $sformatf("ldData hold v%0d", i), ldData, lastLd);
      end
    end

    // R10: back-to-back loads, then pulse ends and data holds
    @(negedge clk);
    reqValid = 1'b1; reqOp = 4'h2; reqBase = 32'h00006000; reqOffset = 16'h0;
    memRdata = 32'h11223344;
    @(negedge clk);
    chk("R10", "b2b first ldValid", {31'b0, ldValid}, 32'h1);
    chk("R9", "b2b first ldData", ldData, 32'h11223344);
    reqOp = 4'h4; reqOffset = 16'h0001; memRdata = 32'hAABBCCDD;
    @(negedge clk);
    chk("R10", "b2b second ldValid", {31'b0, ldValid}, 32'h1);
    chk("R7", "b2b second ldData", ldData, 32'h000000BB);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R10", "pulse end", {31'b0, ldValid}, 32'h0);
    chk("R10", "data hold", ldData, 32'h000000BB);

    // R11: reset mid-run clears the result
    rstN = 1'b0;
    #1;
    chk("R11", "ldData after reset", ldData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    summary();
  end

endmodule